// File: doc/BRIEF.md
# Shared Interrupt Distributor

This block takes a small set of shared external interrupt lines and steers each one to the interrupt controllers of up to four cores. Every shared interrupt has its own settings: a core mask naming the cores that may receive it, a routing mode (rotating or fixed), a trigger type (level or edge) and a mask bit. Software programs these settings through a single command port. Each command carries an opcode, an interrupt index and a 32-bit data word, and one command is accepted per clock.

Each core gets a wide output vector that lines up with its local controller's inputs. Shared interrupt k lands on local input `IRQ_BASE + k` (24 + k by default). The lower local inputs are left for private per-core sources and are always driven low here. Nothing reaches any core until a global enable command has been seen. Outputs are registered: an input sampled at one rising edge shows on the outputs after that edge.

In fixed routing a level interrupt goes to exactly one core, the lowest set core of its mask, while an edge interrupt is broadcast to every core in the mask. In rotating routing, successive occurrences are handed to the set cores of the mask in turn.

Top module: `irq_distrib`

## Requirements
- R1: After reset all outputs are 0, the global enable is off, every interrupt is masked, every core mask is 0, routing is rotating with edge trigger, and every rotation pointer starts at core 0.
- R2: Opcode 1 sets the global enable (index and data ignored). Before it, no output is ever driven. Once set, the enable stays set until reset.
- R3: Opcode 2 writes the core mask of the indexed interrupt from data bits [NUM_CORE-1:0], where bit c stands for core c. Higher data bits are ignored.
- R4: Opcode 3 writes the routing mode from data bits [1:0] and the trigger type from data bit 4. Mode 0 is rotating and any nonzero value is fixed. Bit 4 set means level and clear means edge. All other data bits are ignored.
- R5: Opcode 4 masks the indexed interrupt when data bit 0 is 1 and unmasks it when that bit is 0. A masked interrupt drives no output, and edges that arrive while it is masked are dropped.
- R6: Fixed routing with level trigger drives only the lowest set core of the mask. The output follows the input level, one clock later.
- R7: Fixed routing with edge trigger turns each rising input edge into a one-clock pulse on every core in the mask.
- R8: Rotating routing with level trigger assigns the interrupt, when it asserts, to the first set core at or after the pointer, wrapping around. It holds that core even if the mask changes, until the input drops. The pointer then moves to the core after the owner.
- R9: Rotating routing with edge trigger sends each rising edge as a one-clock pulse to the first set core at or after the pointer. The pointer then moves to the core after it.
- R10: A rotating interrupt whose core mask is 0 is delivered to no core.
- R11: Shared interrupt k for core c appears on output bit `c*(IRQ_BASE+NUM_IRQ) + IRQ_BASE + k`. Bits 0 to IRQ_BASE-1 of every core's slice are always 0.
- R12: Commands with an index at or above NUM_IRQ, or with an opcode outside 1 to 4, change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Command opcode |
| cmd_idx_i | input | IDX_W | Shared interrupt index |
| cmd_data_i | input | DATA_W | Command data word |
| irq_i | input | NUM_IRQ | Shared interrupt inputs |
| core_irq_o | output | NUM_CORE*(IRQ_BASE+NUM_IRQ) | Per-core local interrupt vectors, core 0 in the lowest slice |

## Verification
The assertions assume that the shared inputs and the command fields are synchronous to the clock and stable around the rising edge. They also assume reset is applied at start-up before any command is issued. The stimulus changes inputs and commands only on falling edges and issues one command at a time with a clear cycle after it. Edge checks expect the source to drop between two occurrences; the bench always lowers the input and waits at least one clock before raising it again.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_ENABLE   = 3'd1,
        OP_SET_DEST = 3'd2,
        OP_SET_MODE = 3'd3,
        OP_SET_MASK = 3'd4
    } cmd_op_e;

    // field positions inside the command data word
    localparam int MODE_LO  = 0;
    localparam int MODE_HI  = 1;
    localparam int TRIG_BIT = 4;
    localparam int MASK_BIT = 0;

    typedef struct packed {
        logic dest_mode; // 1: fixed routing, 0: rotating
        logic level;     // 1: level trigger, 0: edge trigger
        logic masked;
    } irq_attr_t;

endpackage

// File: rtl/irqd_cfg.sv
module irqd_cfg
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ  = 4,
    parameter int NUM_CORE = 4,
    parameter int IDX_W    = 8,
    parameter int DATA_W   = 32
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               cmd_valid_i,
    input  logic [2:0]                         cmd_op_i,
    input  logic [IDX_W-1:0]                   cmd_idx_i,
    input  logic [DATA_W-1:0]                  cmd_data_i,
    output logic                               en_o,
    output logic [NUM_IRQ-1:0][NUM_CORE-1:0]   dest_o,
    output irq_attr_t [NUM_IRQ-1:0]            attr_o
);

    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(NUM_IRQ);

    typedef struct packed {
        logic                             en;
        logic [NUM_IRQ-1:0][NUM_CORE-1:0] dest;
        irq_attr_t [NUM_IRQ-1:0]          attr;
    } cfg_t;

    cfg_t s_d, s_q;
    logic data_unused;

    assign data_unused = ^cmd_data_i;

    always_comb begin
        s_d = s_q;
        if (cmd_valid_i) begin
            if (cmd_op_i == OP_ENABLE) begin
                s_d.en = 1'b1;
            end
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (cmd_idx_i == IDX_W'(i)) begin
                    case (cmd_op_i)
                        OP_SET_DEST: s_d.dest[i] = cmd_data_i[NUM_CORE-1:0];
                        OP_SET_MODE: begin
                            s_d.attr[i].dest_mode = |cmd_data_i[MODE_HI:MODE_LO];
                            s_d.attr[i].level     = cmd_data_i[TRIG_BIT];
                        end
                        OP_SET_MASK: s_d.attr[i].masked = cmd_data_i[MASK_BIT];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
            for (int i = 0; i < NUM_IRQ; i++) begin
                s_q.attr[i].masked <= 1'b1;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign en_o   = s_q.en;
    assign dest_o = s_q.dest;
    assign attr_o = s_q.attr;

    AST_ENABLE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_o |=> en_o); // R2

    AST_BAD_INDEX_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_idx_i >= IDX_LIMIT) |=> ($stable(dest_o) && $stable(attr_o))); // R12

endmodule

// File: rtl/irqd_lane.sv
module irqd_lane
    import irqd_pkg::*;
#(
    parameter  int NUM_CORE = 4,
    localparam int PTR_W    = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                en_i,
    input  logic                irq_i,
    input  logic [NUM_CORE-1:0] dest_i,
    input  irq_attr_t           attr_i,
    output logic [NUM_CORE-1:0] lines_o
);

    typedef struct packed {
        logic                prev;
        logic                busy;
        logic [PTR_W-1:0]    owner;
        logic [PTR_W-1:0]    ptr;
        logic [NUM_CORE-1:0] lines;
    } lane_t;

    lane_t s_d, s_q;

    logic                active;
    logic                rise;
    logic                pick_ok;
    logic [PTR_W-1:0]    pick;
    logic [PTR_W-1:0]    cand;
    logic [NUM_CORE-1:0] low_oh;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(NUM_CORE - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    function automatic logic [NUM_CORE-1:0] onehot(input logic [PTR_W-1:0] p);
        logic [NUM_CORE-1:0] v;
        v    = '0;
        v[p] = 1'b1;
        return v;
    endfunction

    // first set core at or after the rotation pointer, wrapping
    always_comb begin
        pick_ok = 1'b0;
        pick    = '0;
        cand    = s_q.ptr;
        for (int i = 0; i < NUM_CORE; i++) begin
            if (!pick_ok && dest_i[cand]) begin
                pick_ok = 1'b1;
                pick    = cand;
            end
            cand = step(cand);
        end
    end

    // lowest set core of the mask
    always_comb begin
        low_oh = '0;
        for (int i = NUM_CORE - 1; i >= 0; i--) begin
            if (dest_i[i]) begin
                low_oh    = '0;
                low_oh[i] = 1'b1;
            end
        end
    end

    always_comb begin
        active  = en_i && !attr_i.masked;
        rise    = irq_i && !s_q.prev;
        s_d       = s_q;
        s_d.prev  = irq_i;
        s_d.lines = '0;
        if (attr_i.level) begin
            if (attr_i.dest_mode) begin
                s_d.busy = 1'b0;
                if (active && irq_i) s_d.lines = low_oh;
            end else if (irq_i) begin
                if (s_q.busy) begin
                    if (active) s_d.lines = onehot(s_q.owner);
                end else if (active && pick_ok) begin
                    s_d.busy  = 1'b1;
                    s_d.owner = pick;
                    s_d.lines = onehot(pick);
                end
            end else if (s_q.busy) begin
                s_d.busy = 1'b0;
                s_d.ptr  = step(s_q.owner);
            end
        end else begin
            s_d.busy = 1'b0;
            if (rise && active) begin
                if (attr_i.dest_mode) begin
                    s_d.lines = dest_i;
                end else if (pick_ok) begin
                    s_d.lines = onehot(pick);
                    s_d.ptr   = step(pick);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign lines_o = s_q.lines;

    AST_SINGLE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(attr_i.level || !attr_i.dest_mode) |-> $onehot0(lines_o)); // R6

    AST_GATED_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(en_i && !attr_i.masked) |-> (lines_o == '0)); // R5

    AST_LEVEL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(attr_i.level && !irq_i) |-> (lines_o == '0)); // R8

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!attr_i.level && $past(!attr_i.level) && lines_o != '0) |=> (lines_o == '0)); // R7

    AST_RR_EMPTY_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!attr_i.dest_mode && dest_i == '0 && !s_q.busy) |-> (lines_o == '0)); // R10

endmodule

// File: rtl/irq_distrib.sv
module irq_distrib
    import irqd_pkg::*;
#(
    parameter  int NUM_IRQ  = 4,
    parameter  int NUM_CORE = 4,
    parameter  int IRQ_BASE = 24,
    parameter  int IDX_W    = 8,
    parameter  int DATA_W   = 32,
    localparam int LOCAL_W  = IRQ_BASE + NUM_IRQ
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        cmd_valid_i,
    input  logic [2:0]                  cmd_op_i,
    input  logic [IDX_W-1:0]            cmd_idx_i,
    input  logic [DATA_W-1:0]           cmd_data_i,
    input  logic [NUM_IRQ-1:0]          irq_i,
    output logic [NUM_CORE*LOCAL_W-1:0] core_irq_o
);

    logic                             cfg_en;
    logic [NUM_IRQ-1:0][NUM_CORE-1:0] cfg_dest;
    irq_attr_t [NUM_IRQ-1:0]          cfg_attr;
    logic [NUM_IRQ-1:0][NUM_CORE-1:0] lane_lines;

    irqd_cfg #(
        .NUM_IRQ (NUM_IRQ),
        .NUM_CORE(NUM_CORE),
        .IDX_W   (IDX_W),
        .DATA_W  (DATA_W)
    ) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cmd_valid_i(cmd_valid_i),
        .cmd_op_i   (cmd_op_i),
        .cmd_idx_i  (cmd_idx_i),
        .cmd_data_i (cmd_data_i),
        .en_o       (cfg_en),
        .dest_o     (cfg_dest),
        .attr_o     (cfg_attr)
    );

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_lane
        irqd_lane #(
            .NUM_CORE(NUM_CORE)
        ) u_lane (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .en_i   (cfg_en),
            .irq_i  (irq_i[k]),
            .dest_i (cfg_dest[k]),
            .attr_i (cfg_attr[k]),
            .lines_o(lane_lines[k])
        );
    end

    // place shared interrupt k at local input IRQ_BASE + k of each core
    always_comb begin
        core_irq_o = '0;
        for (int c = 0; c < NUM_CORE; c++) begin
            for (int k = 0; k < NUM_IRQ; k++) begin
                core_irq_o[c*LOCAL_W + IRQ_BASE + k] = lane_lines[k][c];
            end
        end
    end

    AST_QUIET_BEFORE_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(cfg_en) |-> (core_irq_o == '0)); // R2

endmodule

// File: tb/irq_distrib_bench.sv
module irq_distrib_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NI   = 4;
    localparam int NC   = 4;
    localparam int BASE = 24;
    localparam int LW   = BASE + NI;
    localparam int W    = NC * LW;

    logic         clk;
    logic         rst_n;
    logic         cmd_valid;
    logic [2:0]   cmd_op;
    logic [7:0]   cmd_idx;
    logic [31:0]  cmd_data;
    logic [NI-1:0] irq;
    logic [W-1:0] core_irq;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    irq_distrib u_irq_distrib (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cmd_valid_i(cmd_valid),
        .cmd_op_i   (cmd_op),
        .cmd_idx_i  (cmd_idx),
        .cmd_data_i (cmd_data),
        .irq_i      (irq),
        .core_irq_o (core_irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] ev(input int k, input logic [NC-1:0] cores);
        logic [W-1:0] v;
        v = '0;
        for (int c = 0; c < NC; c++) begin
            if (cores[c]) v[c*LW + BASE + k] = 1'b1;
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] exp);
        total++;
        if (core_irq !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, core_irq, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] op, input logic [7:0] idx, input logic [31:0] data);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_idx   = idx;
        cmd_data  = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
        cmd_idx   = 8'd0;
        cmd_data  = 32'd0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_idx = 8'd0; cmd_data = 32'd0;
        irq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1 reset outputs", '0);
    endtask

    task automatic t_enable_gate();
        cmd(3'd2, 8'd0, 32'h1);
        cmd(3'd3, 8'd0, 32'h11);
        cmd(3'd4, 8'd0, 32'h0);
        irq[0] = 1'b1;
        tick(); chk("R2 before enable", '0);
        tick(); chk("R2 before enable hold", '0);
        cmd(3'd1, 8'd7, 32'hDEAD_BEEF);
        tick(); chk("R2 after enable", ev(0, 4'b0001));
        irq[0] = 1'b0;
        tick(); chk("R2 drop", '0);
        // irq1 never unmasked: reset left it masked
        cmd(3'd2, 8'd1, 32'h1);
        cmd(3'd3, 8'd1, 32'h11);
        irq[1] = 1'b1;
        tick(); chk("R1 masked by default", '0);
        irq[1] = 1'b0;
        tick();
    endtask

    task automatic t_dest_level();
        cmd(3'd2, 8'd0, 32'hFFFF_FFFA);   // cores 1 and 3, high bits ignored
        cmd(3'd3, 8'd0, 32'hFFFF_FFFD);   // fixed, level, junk bits ignored
        irq[0] = 1'b1;
        tick(); chk("R6 lowest core R11 mapping", ev(0, 4'b0010));
        tick(); chk("R4 level holds", ev(0, 4'b0010));
        cmd(3'd2, 8'd0, 32'h0000_000C);   // cores 2 and 3
        tick(); chk("R3 new mask lowest", ev(0, 4'b0100));
        irq[0] = 1'b0;
        tick(); chk("R6 drop", '0);
    endtask

    task automatic t_edge_dest();
        cmd(3'd2, 8'd1, 32'h6);
        cmd(3'd3, 8'd1, 32'h1);           // fixed, edge
        cmd(3'd4, 8'd1, 32'h0);
        irq[1] = 1'b1;
        tick(); chk("R7 broadcast pulse", ev(1, 4'b0110));
        tick(); chk("R7 pulse ends", '0);
        irq[1] = 1'b0;
        tick();
        irq[1] = 1'b1;
        tick(); chk("R7 second edge", ev(1, 4'b0110));
        irq[1] = 1'b0;
        tick();
    endtask

    task automatic t_mask();
        cmd(3'd2, 8'd0, 32'h2);
        irq[0] = 1'b1;
        tick(); chk("R5 unmasked level", ev(0, 4'b0010));
        cmd(3'd4, 8'd0, 32'h1);
        tick(); chk("R5 masked", '0);
        cmd(3'd4, 8'd0, 32'h2);           // bit 0 clear: unmask
        tick(); chk("R5 unmasked again", ev(0, 4'b0010));
        irq[0] = 1'b0;
        cmd(3'd4, 8'd1, 32'h1);
        irq[1] = 1'b1;
        tick(); chk("R5 edge while masked", '0);
        cmd(3'd4, 8'd1, 32'h0);
        tick(); chk("R5 masked edge dropped", '0);
        irq[1] = 1'b0;
        tick();
    endtask

    task automatic t_rr_level();
        cmd(3'd2, 8'd2, 32'hD);           // cores 0, 2, 3
        cmd(3'd3, 8'd2, 32'h10);          // rotating, level
        cmd(3'd4, 8'd2, 32'h0);
        irq[2] = 1'b1;
        tick(); chk("R1 pointer starts core0 R8", ev(2, 4'b0001));
        cmd(3'd2, 8'd2, 32'h8);
        tick(); chk("R8 owner held over mask change", ev(2, 4'b0001));
        cmd(3'd2, 8'd2, 32'hD);
        irq[2] = 1'b0;
        tick(); chk("R8 drop", '0);
        irq[2] = 1'b1;
        tick(); chk("R8 next core2", ev(2, 4'b0100));
        irq[2] = 1'b0; tick();
        irq[2] = 1'b1;
        tick(); chk("R8 next core3", ev(2, 4'b1000));
        irq[2] = 1'b0; tick();
        irq[2] = 1'b1;
        tick(); chk("R8 wrap core0", ev(2, 4'b0001));
        irq[2] = 1'b0; tick();
    endtask

    task automatic t_rr_edge();
        cmd(3'd2, 8'd3, 32'hF);
        cmd(3'd3, 8'd3, 32'h0);           // rotating, edge
        cmd(3'd4, 8'd3, 32'h0);
        for (int n = 0; n < 5; n++) begin
            irq[3] = 1'b1;
            tick(); chk("R9 rotate pulse", ev(3, 4'(1 << (n % 4))));
            irq[3] = 1'b0;
            tick(); chk("R9 pulse ends", '0);
        end
    endtask

    task automatic t_rr_zero();
        cmd(3'd2, 8'd3, 32'h0);
        cmd(3'd3, 8'd3, 32'h10);
        irq[3] = 1'b1;
        tick(); chk("R10 empty mask level", '0);
        tick(); chk("R10 empty mask level hold", '0);
        irq[3] = 1'b0;
        cmd(3'd3, 8'd3, 32'h0);
        irq[3] = 1'b1;
        tick(); chk("R10 empty mask edge", '0);
        irq[3] = 1'b0;
        tick();
    endtask

    task automatic t_bad_cmd();
        cmd(3'd4, 8'd0, 32'h1);           // mask irq0 (mask = core1, fixed level)
        cmd(3'd4, 8'd4, 32'h0);
        cmd(3'd4, 8'h80, 32'h0);
        cmd(3'd7, 8'd0, 32'h0);
        cmd(3'd5, 8'd0, 32'h0);
        cmd(3'd2, 8'd5, 32'hF);
        irq[0] = 1'b1;
        tick(); chk("R12 bad commands keep mask", '0);
        cmd(3'd4, 8'd0, 32'h0);
        tick(); chk("R12 mask unchanged by bad index", ev(0, 4'b0010));
        irq[0] = 1'b0;
        tick();
    endtask

    task automatic t_map();
        irq[0] = 1'b1;                    // fixed level, core 1
        irq[1] = 1'b1;                    // fixed edge, cores 1 and 2
        tick(); chk("R11 combined mapping", ev(0, 4'b0010) | ev(1, 4'b0110));
        irq = '0;
        tick(); chk("R11 all clear", '0);
    endtask

    initial begin
        t_reset();
        t_enable_gate();
        t_dest_level();
        t_edge_dest();
        t_mask();
        t_rr_level();
        t_rr_edge();
        t_rr_zero();
        t_bad_cmd();
        t_map();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL timeout all-requirements got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule